// File: doc/BRIEF.md
# Cell Output Grant Arbiter

This block is the grant stage at the centre of a small cell switch. It has four network ports and one or more application ports, and the same number of inputs and outputs. An input announces the head of a new cell with a one-cycle request. The request carries a target output index and a 48-bit word, which holds the cell header plus its first payload byte.

Before arbitration, a filter compares the virtual path and virtual channel fields of each network-input header with a set of configured application identifiers. On a hit, the cell is either steered to that identifier's application output or marked for discard.

For every output, the arbiter then grants at most one contender per cycle. A cell already holding an output keeps it for a full cell time. Among newcomers in the same cycle, the lowest input index wins. All other requests are rejected and never queued: the requesting input flushes the rejected cell.

The granted header word is loaded into the reassembly register of the chosen output, together with the index of the input it came from.

The request and output streams are valid-only. The arbiter never back-pressures an input: a reject pulse takes the place of a ready signal, and the input drops the cell. The output register is assumed always free to load, so `out_valid` is a single-cycle strobe with no ready. An input must not raise a new head while a cell it sent earlier is still in transmission. That rule belongs to the caller and is not checked here.

Top module: `cell_out_arbiter`

## Requirements
- R1: During and right after reset, `in_grant`, `in_reject` and `out_valid` are all low.
- R2: Every input that raises `in_valid` in cycle t gets exactly one of `in_grant` or `in_reject` for one cycle, in cycle t+2. No input gets either without a request.
- R3: When several inputs target the same free output in the same cycle, only the lowest-numbered one is granted and every other contender is rejected. Requests to distinct free outputs are all granted.
- R4: After a grant, its output stays taken for CELL_LEN cycles. A request whose decision falls inside that window is rejected, even when it comes from a lower-numbered input. A request decided CELL_LEN or more cycles after the grant can be granted.
- R5: A cell granted in cycle t+2 appears in cycle t+3 on its output as `out_valid`=1, with `out_hdr` equal to the requested word and `out_src` equal to the granting input's index. Every other output stays idle that cycle.
- R6: For a network input (index below NUM_NET), if header bits [43:36] equal an enabled identifier's VPI and bits [35:20] equal its VCI, the cell goes to output NUM_NET+k regardless of `in_dest`. When several identifiers match, the lowest k wins.
- R7: If the winning matched identifier has its drop flag set, the cell is rejected and no output is loaded.
- R8: Cells from application inputs (index NUM_NET and above) bypass the filter and use `in_dest` as given.
- R9: A destination index of NUM_NET+NUM_APP or more is rejected.
- R10: An identifier whose enable bit is low never matches. A header matching the VPI but not the VCI does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_app_en | input | NUM_APP | Per-identifier enable |
| cfg_app_drop | input | NUM_APP | Per-identifier discard instead of steer |
| cfg_app_vpi | input | 8*NUM_APP | Identifier VPI values, k-th at [8k+:8] |
| cfg_app_vci | input | 16*NUM_APP | Identifier VCI values, k-th at [16k+:16] |
| in_valid | input | NI | Cell head request per input |
| in_dest | input | DW*NI | Target output per input |
| in_hdr | input | 48*NI | Header word per input |
| in_grant | output | NI | Grant pulse per input |
| in_reject | output | NI | Reject pulse per input |
| out_valid | output | NO | Reassembly register load strobe per output |
| out_src | output | SW*NO | Granted input index per output |
| out_hdr | output | 48*NO | Header word per output |

## Verification
A request driven in cycle t gets its verdict two register stages later, in t+2. The loaded output appears one stage after that, in t+3. The bench drives each request on a falling edge, reads the grant and reject vectors two falling edges later and the outputs one falling edge after that. It then idles more than a cell time so that every output is free for the next trial. The busy-window cases place a second request exactly k cycles after a first one and sample its verdict at its own t+2. This pins the boundary at CELL_LEN-1 (reject) against CELL_LEN (grant).

// File: rtl/cell_arb_pkg.sv
package cell_arb_pkg;
  localparam int HDR_W   = 48;
  localparam int VPI_W   = 8;
  localparam int VCI_W   = 16;
  localparam int VPI_LSB = 36;
  localparam int VCI_LSB = 20;

  function automatic logic [VPI_W-1:0] hdr_vpi(input logic [HDR_W-1:0] h);
    return h[VPI_LSB +: VPI_W];
  endfunction

  function automatic logic [VCI_W-1:0] hdr_vci(input logic [HDR_W-1:0] h);
    return h[VCI_LSB +: VCI_W];
  endfunction
endpackage

// File: rtl/cell_arb_classify.sv
module cell_arb_classify
  import cell_arb_pkg::*;
#(
  parameter int NUM_NET = 4,
  parameter int NUM_APP = 1,
  parameter int NI      = 5,
  parameter int DW      = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_APP-1:0]     cfg_app_en,
  input  logic [NUM_APP-1:0]     cfg_app_drop,
  input  logic [NUM_APP*VPI_W-1:0] cfg_app_vpi,
  input  logic [NUM_APP*VCI_W-1:0] cfg_app_vci,
  input  logic [NI-1:0]          in_valid,
  input  logic [NI*DW-1:0]       in_dest,
  input  logic [NI*HDR_W-1:0]    in_hdr,
  output logic [NI-1:0]          s1_valid,
  output logic [NI-1:0]          s1_drop,
  output logic [NI*DW-1:0]       s1_dest,
  output logic [NI*HDR_W-1:0]    s1_hdr
);
  for (genvar i = 0; i < NI; i++) begin : g_in
    logic [HDR_W-1:0] hdr_i;
    logic [DW-1:0]    dst_c;
    logic             drop_c;
    logic             v_q, drop_q;
    logic [DW-1:0]    dst_q;
    logic [HDR_W-1:0] hdr_q;

    assign hdr_i = in_hdr[i*HDR_W +: HDR_W];

    if (i < NUM_NET) begin : g_net
      always_comb begin
        dst_c  = in_dest[i*DW +: DW];
        drop_c = 1'b0;
        for (int k = NUM_APP-1; k >= 0; k--) begin
          if (cfg_app_en[k] &&
              hdr_vpi(hdr_i) == cfg_app_vpi[k*VPI_W +: VPI_W] &&
              hdr_vci(hdr_i) == cfg_app_vci[k*VCI_W +: VCI_W]) begin
            dst_c  = DW'(NUM_NET + k);
            drop_c = cfg_app_drop[k];
          end
        end
      end
    end else begin : g_app
      assign dst_c  = in_dest[i*DW +: DW];
      assign drop_c = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q    <= 1'b0;
        drop_q <= 1'b0;
        dst_q  <= '0;
        hdr_q  <= '0;
      end else begin
        v_q    <= in_valid[i];
        drop_q <= drop_c;
        dst_q  <= dst_c;
        hdr_q  <= hdr_i;
      end
    end

    assign s1_valid[i]               = v_q;
    assign s1_drop[i]                = drop_q;
    assign s1_dest[i*DW +: DW]       = dst_q;
    assign s1_hdr[i*HDR_W +: HDR_W]  = hdr_q;
  end
endmodule

// File: rtl/cell_arb_grant.sv
module cell_arb_grant #(
  parameter int NI       = 5,
  parameter int NO       = 5,
  parameter int DW       = 3,
  parameter int SW       = 3,
  parameter int CELL_LEN = 53
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NI-1:0]    s1_valid,
  input  logic [NI-1:0]    s1_drop,
  input  logic [NI*DW-1:0] s1_dest,
  output logic [NI-1:0]    in_grant,
  output logic [NI-1:0]    in_reject,
  output logic [NO-1:0]    g_valid,
  output logic [NO*SW-1:0] g_src
);
  localparam int CW = $clog2(CELL_LEN + 1);

  logic [NI-1:0] win_v [NO];
  logic [NI-1:0] grant_c;

  for (genvar o = 0; o < NO; o++) begin : g_out
    logic [NI-1:0] want;
    logic [CW-1:0] cnt;
    logic          free;
    logic          win_any;
    logic [SW-1:0] idx;
    logic          gv_q;
    logic [SW-1:0] gs_q;

    always_comb begin
      for (int i = 0; i < NI; i++)
        want[i] = s1_valid[i] & ~s1_drop[i] & (s1_dest[i*DW +: DW] == DW'(o));
    end

    assign free     = (cnt == '0);
    assign win_any  = free & (|want);
    assign win_v[o] = free ? (want & (~want + NI'(1))) : '0;

    always_comb begin
      idx = '0;
      for (int i = NI-1; i >= 0; i--)
        if (want[i]) idx = SW'(i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt  <= '0;
        gv_q <= 1'b0;
        gs_q <= '0;
      end else begin
        if (win_any)         cnt <= CW'(CELL_LEN - 1);
        else if (cnt != '0)  cnt <= cnt - CW'(1);
        gv_q <= win_any;
        gs_q <= idx;
      end
    end

    assign g_valid[o]           = gv_q;
    assign g_src[o*SW +: SW]    = gs_q;
  end

  always_comb begin
    grant_c = '0;
    for (int o = 0; o < NO; o++) grant_c = grant_c | win_v[o];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_grant  <= '0;
      in_reject <= '0;
    end else begin
      in_grant  <= grant_c;
      in_reject <= s1_valid & ~grant_c;
    end
  end
endmodule

// File: rtl/cell_arb_route.sv
module cell_arb_route
  import cell_arb_pkg::*;
#(
  parameter int NI = 5,
  parameter int NO = 5,
  parameter int SW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NI*HDR_W-1:0] s1_hdr,
  input  logic [NO-1:0]       g_valid,
  input  logic [NO*SW-1:0]    g_src,
  output logic [NO-1:0]       out_valid,
  output logic [NO*SW-1:0]    out_src,
  output logic [NO*HDR_W-1:0] out_hdr
);
  logic [HDR_W-1:0] s2_hdr [NI];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NI; i++) s2_hdr[i] <= '0;
    end else begin
      for (int i = 0; i < NI; i++) s2_hdr[i] <= s1_hdr[i*HDR_W +: HDR_W];
    end
  end

  for (genvar o = 0; o < NO; o++) begin : g_out
    logic [SW-1:0]    src;
    logic [HDR_W-1:0] sel;
    logic             v_q;
    logic [SW-1:0]    s_q;
    logic [HDR_W-1:0] h_q;

    assign src = g_src[o*SW +: SW];

    always_comb begin
      sel = '0;
      for (int i = 0; i < NI; i++)
        if (src == SW'(i)) sel = s2_hdr[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        s_q <= '0;
        h_q <= '0;
      end else begin
        v_q <= g_valid[o];
        if (g_valid[o]) begin
          s_q <= src;
          h_q <= sel;
        end
      end
    end

    assign out_valid[o]                = v_q;
    assign out_src[o*SW +: SW]         = s_q;
    assign out_hdr[o*HDR_W +: HDR_W]   = h_q;
  end
endmodule

// File: rtl/cell_out_arbiter.sv
module cell_out_arbiter #(
  parameter int NUM_NET  = 4,
  parameter int NUM_APP  = 1,
  parameter int CELL_LEN = 53,
  localparam int NI      = NUM_NET + NUM_APP,
  localparam int NO      = NUM_NET + NUM_APP,
  localparam int DW      = (NO > 1) ? $clog2(NO) : 1,
  localparam int SW      = (NI > 1) ? $clog2(NI) : 1,
  localparam int HW      = 48
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_APP-1:0]    cfg_app_en,
  input  logic [NUM_APP-1:0]    cfg_app_drop,
  input  logic [NUM_APP*8-1:0]  cfg_app_vpi,
  input  logic [NUM_APP*16-1:0] cfg_app_vci,
  input  logic [NI-1:0]         in_valid,
  input  logic [NI*DW-1:0]      in_dest,
  input  logic [NI*HW-1:0]      in_hdr,
  output logic [NI-1:0]         in_grant,
  output logic [NI-1:0]         in_reject,
  output logic [NO-1:0]         out_valid,
  output logic [NO*SW-1:0]      out_src,
  output logic [NO*HW-1:0]      out_hdr
);
  logic [NI-1:0]    s1_valid, s1_drop;
  logic [NI*DW-1:0] s1_dest;
  logic [NI*HW-1:0] s1_hdr;
  logic [NO-1:0]    g_valid;
  logic [NO*SW-1:0] g_src;

  cell_arb_classify #(.NUM_NET(NUM_NET), .NUM_APP(NUM_APP), .NI(NI), .DW(DW)) u_cls (
    .clk(clk), .rst_n(rst_n),
    .cfg_app_en(cfg_app_en), .cfg_app_drop(cfg_app_drop),
    .cfg_app_vpi(cfg_app_vpi), .cfg_app_vci(cfg_app_vci),
    .in_valid(in_valid), .in_dest(in_dest), .in_hdr(in_hdr),
    .s1_valid(s1_valid), .s1_drop(s1_drop), .s1_dest(s1_dest), .s1_hdr(s1_hdr)
  );

  cell_arb_grant #(.NI(NI), .NO(NO), .DW(DW), .SW(SW), .CELL_LEN(CELL_LEN)) u_grant (
    .clk(clk), .rst_n(rst_n),
    .s1_valid(s1_valid), .s1_drop(s1_drop), .s1_dest(s1_dest),
    .in_grant(in_grant), .in_reject(in_reject),
    .g_valid(g_valid), .g_src(g_src)
  );

  cell_arb_route #(.NI(NI), .NO(NO), .SW(SW)) u_route (
    .clk(clk), .rst_n(rst_n),
    .s1_hdr(s1_hdr), .g_valid(g_valid), .g_src(g_src),
    .out_valid(out_valid), .out_src(out_src), .out_hdr(out_hdr)
  );
endmodule

// File: rtl/cell_arb_checker.sv
module cell_arb_checker #(
  parameter int NI       = 5,
  parameter int NO       = 5,
  parameter int CELL_LEN = 53
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NI-1:0] in_valid,
  input logic [NI-1:0] in_grant,
  input logic [NI-1:0] in_reject,
  input logic [NO-1:0] out_valid
);
  localparam int GW = $clog2(CELL_LEN + 1);

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R2: grant and reject never together for one input
  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (in_grant & in_reject) == '0);

  // R2: each request answered exactly two cycles later, nothing else answered
  a_r2_response: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> ((in_grant | in_reject) == $past(in_valid, 2)));

  // R5: one output load per grant, one cycle after it
  a_r5_load_per_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1) |-> ($countones(out_valid) == $countones($past(in_grant))));

  // R1: nothing active in the first cycle after reset
  a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd0) |-> (in_grant == '0 && in_reject == '0 && out_valid == '0));

  for (genvar o = 0; o < NO; o++) begin : g_gap
    logic [GW-1:0] gap;
    logic          seen;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gap  <= '0;
        seen <= 1'b0;
      end else if (out_valid[o]) begin
        gap  <= '0;
        seen <= 1'b1;
      end else if (gap != GW'(CELL_LEN)) begin
        gap  <= gap + GW'(1);
      end
    end

    // R4: an output is not loaded again within one cell time
    a_r4_cell_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && seen) |-> (gap >= GW'(CELL_LEN - 1)));
  end
endmodule

bind cell_out_arbiter cell_arb_checker #(
  .NI(NUM_NET + NUM_APP), .NO(NUM_NET + NUM_APP), .CELL_LEN(CELL_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .in_grant(in_grant), .in_reject(in_reject), .out_valid(out_valid)
);

// File: tb/cell_out_arbiter_test.sv
module cell_out_arbiter_test;
  localparam int NUM_NET  = 4;
  localparam int NUM_APP  = 2;
  localparam int CELL_LEN = 6;
  localparam int N        = NUM_NET + NUM_APP;
  localparam int DW       = 3;
  localparam int SW       = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NUM_APP-1:0]    cfg_app_en = '0, cfg_app_drop = '0;
  logic [NUM_APP*8-1:0]  cfg_app_vpi = '0;
  logic [NUM_APP*16-1:0] cfg_app_vci = '0;
  logic [N-1:0]    in_valid = '0;
  logic [N*DW-1:0] in_dest = '0;
  logic [N*48-1:0] in_hdr = '0;
  logic [N-1:0]    in_grant, in_reject, out_valid;
  logic [N*SW-1:0] out_src;
  logic [N*48-1:0] out_hdr;

  cell_out_arbiter #(.NUM_NET(NUM_NET), .NUM_APP(NUM_APP), .CELL_LEN(CELL_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_app_en(cfg_app_en), .cfg_app_drop(cfg_app_drop),
    .cfg_app_vpi(cfg_app_vpi), .cfg_app_vci(cfg_app_vci),
    .in_valid(in_valid), .in_dest(in_dest), .in_hdr(in_hdr),
    .in_grant(in_grant), .in_reject(in_reject),
    .out_valid(out_valid), .out_src(out_src), .out_hdr(out_hdr));

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] mkhdr(input logic [7:0] vpi, input logic [15:0] vci, input logic [15:0] tag);
    return {4'h0, vpi, vci, 4'h0, tag};
  endfunction

  int          td [N];
  logic [47:0] th [N];

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive one head per masked input, predict verdicts and outputs from the rules.
  task automatic trial(input logic [N-1:0] mask, input string req);
    int  ed [N];
    bit  dr [N];
    logic [N-1:0] eg, er, ev;
    int  esrc [N];
    eg = '0; er = '0; ev = '0;
    for (int i = 0; i < N; i++) begin
      ed[i] = td[i]; dr[i] = 0;
      if (i < NUM_NET) begin
        for (int k = 0; k < NUM_APP; k++) begin
          if (cfg_app_en[k] && th[i][43:36] == cfg_app_vpi[k*8 +: 8] &&
              th[i][35:20] == cfg_app_vci[k*16 +: 16]) begin
            ed[i] = NUM_NET + k; dr[i] = cfg_app_drop[k];
            break;
          end
        end
      end
    end
    for (int o = 0; o < N; o++) begin
      esrc[o] = 0;
      for (int i = 0; i < N; i++) begin
        if (mask[i] && !dr[i] && ed[i] == o && !ev[o]) begin
          ev[o] = 1'b1; esrc[o] = i; eg[i] = 1'b1;
        end
      end
    end
    er = mask & ~eg;
    for (int i = 0; i < N; i++) begin
      in_dest[i*DW +: DW] = td[i][DW-1:0];
      in_hdr[i*48 +: 48]  = th[i];
    end
    in_valid = mask;
    @(negedge clk);
    in_valid = '0;
    @(negedge clk);
    chk(in_grant == eg, {req, " grant"}, 64'(in_grant), 64'(eg));
    chk(in_reject == er, {req, " reject"}, 64'(in_reject), 64'(er));
    @(negedge clk);
    chk(out_valid == ev, {req, " out_valid"}, 64'(out_valid), 64'(ev));
    for (int o = 0; o < N; o++) begin
      if (ev[o]) begin
        chk(out_src[o*SW +: SW] == SW'(esrc[o]), {req, " out_src"}, 64'(out_src[o*SW +: SW]), 64'(esrc[o]));
        chk(out_hdr[o*48 +: 48] == th[esrc[o]], {req, " out_hdr"}, 64'(out_hdr[o*48 +: 48]), 64'(th[esrc[o]]));
      end
    end
    idle(CELL_LEN + 2);
  endtask

  // Input 3 takes output 1; k cycles later input 0 asks for output 1.
  task automatic busy_test(input int k);
    bit exp;
    exp = (k >= CELL_LEN);
    in_dest = '0;
    in_dest[3*DW +: DW] = 3'd1;
    in_hdr[3*48 +: 48]  = mkhdr(8'h00, 16'hB000, 16'(k));
    in_valid = 6'b001000;
    @(negedge clk);
    in_valid = '0;
    repeat (k - 1) @(negedge clk);
    in_dest[0 +: DW]  = 3'd1;
    in_hdr[0 +: 48]   = mkhdr(8'h00, 16'hB100, 16'(k));
    in_valid = 6'b000001;
    @(negedge clk);
    in_valid = '0;
    @(negedge clk);
    chk(in_grant[0] == exp && in_reject[0] == !exp, "R4 late request verdict",
        64'({in_grant[0], in_reject[0]}), 64'({exp, !exp}));
    @(negedge clk);
    chk(out_valid[1] == exp, "R4 late request load", 64'(out_valid[1]), 64'(exp));
    if (exp)
      chk(out_src[1*SW +: SW] == 3'd0, "R4 new holder src", 64'(out_src[1*SW +: SW]), 64'd0);
    idle(CELL_LEN + 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_grant == '0 && in_reject == '0 && out_valid == '0, "R1 reset state",
        64'({in_grant, in_reject, out_valid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_grant == '0 && in_reject == '0 && out_valid == '0, "R1 after reset",
        64'({in_grant, in_reject, out_valid}), 64'd0);

    // R3 sweep: every subset of inputs racing for one output
    for (int o = 0; o < N; o++) begin
      for (int m = 1; m < (1 << N); m++) begin
        for (int i = 0; i < N; i++) begin
          td[i] = o; th[i] = mkhdr(8'h00, 16'(o*64 + m), 16'(i));
        end
        trial(N'(m), "R3 collision");
      end
    end

    // R9 and R3: rotated distinct targets, some beyond the last output
    for (int s = 0; s < 8; s++) begin
      for (int i = 0; i < N; i++) begin
        td[i] = (i + s) % 8; th[i] = mkhdr(8'h01, 16'(s), 16'(i));
      end
      trial('1, "R9 rotate");
    end

    // R4: busy window and no pre-emption by a lower index
    busy_test(2);
    busy_test(CELL_LEN - 1);
    busy_test(CELL_LEN);
    busy_test(CELL_LEN + 3);

    // Filter cases
    cfg_app_vpi = {8'h12, 8'h12};
    cfg_app_vci = {16'h3456, 16'h3456};
    cfg_app_en  = 2'b11;
    cfg_app_drop = 2'b00;
    for (int i = 0; i < N; i++) begin td[i] = 0; th[i] = mkhdr(8'h00, 16'h0, 16'(i)); end
    td[1] = 2; th[1] = mkhdr(8'h12, 16'h3456, 16'hA1);
    trial(6'b000010, "R6 steer lowest id");
    cfg_app_en = 2'b10;
    trial(6'b000010, "R10 disabled id skipped");
    cfg_app_drop = 2'b10;
    trial(6'b000010, "R7 drop");
    td[4] = 0; th[4] = mkhdr(8'h12, 16'h3456, 16'hA4);
    trial(6'b010000, "R8 app input bypass");
    cfg_app_drop = 2'b00;
    td[2] = 3; th[2] = mkhdr(8'h12, 16'h3457, 16'hA2);
    trial(6'b000100, "R10 vci mismatch");
    cfg_app_en = 2'b01;
    td[0] = 1; th[0] = mkhdr(8'h12, 16'h3456, 16'hA0);
    td[3] = 4; th[3] = mkhdr(8'h00, 16'h0, 16'hA3);
    trial(6'b001001, "R6 steer collides with direct");
    cfg_app_en = 2'b00;
    trial(6'b000010, "R10 all disabled");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule